// File: doc/BRIEF.md
# DMA Channel Enable and Interrupt Control

This block holds the arming, enabling and interrupt logic for a small number of channels of a simple DMA engine. Each channel has a control word with four bits (transfer enable, master enable, end-interrupt enable and break-interrupt enable) and a 16-bit transfer counter. A CPU reaches both through one register port with read and write strobes. When both enables are set, an activation request from the channel's source starts a transfer. When the transfer enable is off, requests are ignored. If the ignored request comes from an internal interrupt source, it is passed on to the CPU as an ordinary interrupt instead.

The transfer enable is deliberately hard to set by accident. A write of 1 takes effect only when the CPU has read the control word back with the enable at 0 since its last write to that word. The enable drops when the counter runs out, when software writes 0, or on reset. Each of those falls can raise a transfer-end interrupt. Clearing the master enable can raise a transfer-break interrupt. Both interrupts are held levels that stay high until their own cancel condition occurs.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, every control word and every counter reads 0, and every output is low.
- R2: The register address is {channel, select}. Select 0 is the control word: bit 0 transfer enable, bit 1 master enable, bit 2 end-interrupt enable, bit 3 break-interrupt enable. Select 1 is the counter. A write of 1 to bit 0 sets the transfer enable only if a read of that channel's control word has returned the enable as 0 since the last write to that control word. Without such a read, the enable stays 0.
- R3: Any write to a control word consumes the arming left by an earlier read. This holds even when the write leaves bit 0 at 0, so a second write of 1 without a new read has no effect.
- R4: `xfer_start` for a channel is high in the same cycle as its activation request only when both the transfer enable and the master enable are 1.
- R5: While the transfer enable is 0, a request flagged as an internal interrupt drives `cpu_irq` high in the same cycle and starts no transfer. A request not so flagged drives neither output.
- R6: A CPU write of 0 to bit 0 clears the transfer enable on the next clock.
- R7: A write with select 1 loads the counter. Each `xfer_done` pulse decrements a nonzero count. The pulse that takes the count from 1 to 0 clears the transfer enable.
- R8: A 1-to-0 change of the transfer enable while the end-interrupt enable is 1 raises `end_irq` on the next clock. It stays high until the end-interrupt enable is written 0 or the transfer enable is set again.
- R9: Clearing the master enable while the break-interrupt enable is 1 raises `brk_irq` on the next clock. It stays high until the break-interrupt enable is written 0 or the master enable is written 1.
- R10: An activation request in the same cycle in which the transfer enable is being cleared, by a write of 0 or by the final count, does not start a transfer.
- R11: Channels are independent: a read of one channel's control word does not arm another, and requests on one channel do not start another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | CPU write strobe |
| reg_rd | input | 1 | CPU read strobe (arms the enable when it reads bit 0 as 0) |
| reg_addr | input | ADDR_W | {channel, select}; select 0 = control word, 1 = counter |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr`, combinational |
| act_req | input | NUM_CH | Activation request per channel |
| act_is_irq | input | NUM_CH | Request comes from an internal interrupt source |
| xfer_done | input | NUM_CH | One-cycle pulse per completed transfer |
| xfer_start | output | NUM_CH | Transfer start strobe |
| end_irq | output | NUM_CH | Transfer-end interrupt level |
| brk_irq | output | NUM_CH | Transfer-break interrupt level |
| cpu_irq | output | NUM_CH | Ignored internal-interrupt request passed to the CPU |

## Verification
The arming flag is internal state that software cannot read. If it is wrong, the only sign is a write of 1 that changes or fails to change bit 0, and that shows in the very next control read. A wrong enable bit shows in `xfer_start` or `cpu_irq` in the same cycle as the next request. A counter that is off by one delays or advances the enable's fall, and `end_irq` shows that a clock later. A missed set or cancel of an interrupt level stays visible on its output until the next cancel event. The tests therefore sample outputs between scripted steps, and never only at the end.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int BIT_EN  = 0;
  localparam int BIT_MST = 1;
  localparam int BIT_EIE = 2;
  localparam int BIT_BIE = 3;
  localparam int CTRL_W  = 4;

  // Next transfer-enable value: the final count wins, a write of 0 clears,
  // and a write of 1 sets only when armed.
  function automatic logic en_next(input logic en, input logic arm,
                                   input logic wr, input logic wbit,
                                   input logic done);
    if (done)    return 1'b0;
    else if (wr) return wbit ? (en | arm) : 1'b0;
    else         return en;
  endfunction

  // Next value of a held interrupt level.
  function automatic logic irq_next(input logic cur, input logic set_ev,
                                    input logic ie, input logic cancel_ev);
    if (set_ev && ie)          return 1'b1;
    else if (!ie || cancel_ev) return 1'b0;
    else                       return cur;
  endfunction
endpackage

// File: rtl/dmach_counter.sv
module dmach_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         done
);
  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] cnt_next(input logic [W-1:0] c,
                                            input logic ld,
                                            input logic [W-1:0] v,
                                            input logic st);
    if (ld)                    return v;
    else if (st && c != '0)    return c - ONE;
    else                       return c;
  endfunction

  logic [W-1:0] cnt_q;

  assign done  = step && (cnt_q == ONE);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next(cnt_q, load, load_val, step);
  end

  a_r7_done_reaches_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> (count == '0));
endmodule

// File: rtl/dmach_channel.sv
module dmach_channel
  import dmach_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              ctrl_rd,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              act_req,
  input  logic              act_is_irq,
  input  logic              xfer_done,
  output logic              xfer_start,
  output logic              end_irq,
  output logic              brk_irq,
  output logic              cpu_irq,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [CNT_W-1:0]  count
);
  logic en_q, mst_q, eie_q, bie_q, arm_q, end_q, brk_q;
  logic en_nx, mst_nx, eie_nx, bie_nx, arm_nx;
  logic en_rise, en_fall, mst_rise, mst_fall;
  logic count_done;

  dmach_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_wr), .load_val(wdata),
    .step(xfer_done), .count(count), .done(count_done)
  );

  always_comb begin
    en_nx  = en_next(en_q, arm_q, ctrl_wr, wdata[BIT_EN], count_done);
    mst_nx = ctrl_wr ? wdata[BIT_MST] : mst_q;
    eie_nx = ctrl_wr ? wdata[BIT_EIE] : eie_q;
    bie_nx = ctrl_wr ? wdata[BIT_BIE] : bie_q;
    if (ctrl_wr)               arm_nx = 1'b0;
    else if (ctrl_rd && !en_q) arm_nx = 1'b1;
    else                       arm_nx = arm_q;
  end

  assign en_rise  = !en_q && en_nx;
  assign en_fall  = en_q && !en_nx;
  assign mst_rise = !mst_q && mst_nx;
  assign mst_fall = mst_q && !mst_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; mst_q <= 1'b0; eie_q <= 1'b0; bie_q <= 1'b0;
      arm_q <= 1'b0; end_q <= 1'b0; brk_q <= 1'b0;
    end else begin
      en_q  <= en_nx;
      mst_q <= mst_nx;
      eie_q <= eie_nx;
      bie_q <= bie_nx;
      arm_q <= arm_nx;
      end_q <= irq_next(end_q, en_fall, eie_nx, en_rise);
      brk_q <= irq_next(brk_q, mst_fall, bie_nx, mst_rise);
    end
  end

  assign xfer_start = act_req && en_q && en_nx && mst_q;
  assign cpu_irq    = act_req && act_is_irq && !en_q;
  assign end_irq    = end_q;
  assign brk_irq    = brk_q;

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[BIT_EN]  = en_q;
    ctrl_word[BIT_MST] = mst_q;
    ctrl_word[BIT_EIE] = eie_q;
    ctrl_word[BIT_BIE] = bie_q;
  end

  a_r2_rise_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |-> arm_q);
  a_r3_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !arm_q);
  a_r5_pass_excludes_start: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> !xfer_start);
  a_r8_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && eie_nx) |=> end_irq);
  a_r9_brk_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_fall && bie_nx) |=> brk_irq);
  a_r10_no_start_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |-> !xfer_start);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dmach_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic [NUM_CH-1:0] act_req,
  input  logic [NUM_CH-1:0] act_is_irq,
  input  logic [NUM_CH-1:0] xfer_done,
  output logic [NUM_CH-1:0] xfer_start,
  output logic [NUM_CH-1:0] end_irq,
  output logic [NUM_CH-1:0] brk_irq,
  output logic [NUM_CH-1:0] cpu_irq
);
  logic [CH_W-1:0]   sel_ch;
  logic              sel_cnt;
  logic [CTRL_W-1:0] ctrl_w [NUM_CH];
  logic [CNT_W-1:0]  cnt_w  [NUM_CH];

  assign sel_ch  = reg_addr[ADDR_W-1:1];
  assign sel_cnt = reg_addr[0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = (sel_ch == CH_W'(i));
    dmach_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr(reg_wr && hit && !sel_cnt),
      .ctrl_rd(reg_rd && hit && !sel_cnt),
      .cnt_wr(reg_wr && hit && sel_cnt),
      .wdata(reg_wdata),
      .act_req(act_req[i]), .act_is_irq(act_is_irq[i]), .xfer_done(xfer_done[i]),
      .xfer_start(xfer_start[i]), .end_irq(end_irq[i]), .brk_irq(brk_irq[i]),
      .cpu_irq(cpu_irq[i]), .ctrl_word(ctrl_w[i]), .count(cnt_w[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_ch == CH_W'(i))
        reg_rdata = sel_cnt ? cnt_w[i] : CNT_W'(ctrl_w[i]);
    end
  end

  a_r11_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start & ~act_req) == '0);
endmodule

// File: tb/dma_chan_ctrl_bench.sv
module dma_chan_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 2;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [CNT_W-1:0] reg_wdata = '0, reg_rdata;
  logic [NUM_CH-1:0] act_req = '0, act_is_irq = '0, xfer_done = '0;
  logic [NUM_CH-1:0] xfer_start, end_irq, brk_irq, cpu_irq;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dma_chan_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .act_req(act_req), .act_is_irq(act_is_irq), .xfer_done(xfer_done),
    .xfer_start(xfer_start), .end_irq(end_irq), .brk_irq(brk_irq), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input int ch, input bit cnt, input logic [CNT_W-1:0] d);
    reg_addr = {ch[0], cnt}; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input bit cnt, output logic [CNT_W-1:0] d);
    reg_addr = {ch[0], cnt}; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic arm_wr(input int ch, input logic [CNT_W-1:0] d);
    logic [CNT_W-1:0] tmp;
    rd(ch, 0, tmp);
    wr(ch, 0, d);
  endtask

  task automatic t_reset();
    logic [CNT_W-1:0] d;
    for (int c = 0; c < NUM_CH; c++) begin
      rd(c, 0, d); chk("R1 ctrl after reset", d, 0);
      rd(c, 1, d); chk("R1 count after reset", d, 0);
    end
    chk("R1 outputs after reset", {xfer_start, end_irq, brk_irq, cpu_irq}, 0);
    wr(0, 0, 0); wr(1, 0, 0);
  endtask

  task automatic t_arming();
    logic [CNT_W-1:0] d;
    wr(0, 0, 16'h1);
    rd(0, 0, d); chk("R2 write 1 without read", d, 0);
    wr(0, 0, 16'h1);
    rd(0, 0, d); chk("R2 write 1 after read of 0", d, 16'h1);
    wr(0, 0, 16'h0);
    rd(0, 0, d); chk("R6 write 0 clears enable", d, 0);
    wr(0, 0, 16'h2);
    wr(0, 0, 16'h3);
    rd(0, 0, d); chk("R3 arming consumed by earlier write", d, 16'h2);
    wr(0, 0, 0);
  endtask

  task automatic t_start();
    arm_wr(0, 16'h3);
    act_req[0] = 1'b1; act_is_irq[0] = 1'b0; #1;
    chk("R4 start with both enables", xfer_start, 2'b01);
    chk("R4 no cpu irq when enabled", cpu_irq, 0);
    @(negedge clk); act_req = '0;
    wr(0, 0, 16'h1);
    act_req[0] = 1'b1; #1;
    chk("R4 no start without master", xfer_start, 0);
    @(negedge clk); act_req = '0;
    wr(0, 0, 0);
  endtask

  task automatic t_pass();
    act_req[0] = 1'b1; act_is_irq[0] = 1'b1; #1;
    chk("R5 internal source passed to cpu", cpu_irq, 2'b01);
    chk("R5 no start when disabled", xfer_start, 0);
    @(negedge clk); act_is_irq = '0; #1;
    chk("R5 external source ignored", {cpu_irq, xfer_start}, 0);
    @(negedge clk); act_req = '0;
  endtask

  task automatic pulse_done(input int ch);
    xfer_done[ch] = 1'b1; @(negedge clk); xfer_done[ch] = 1'b0;
  endtask

  task automatic t_count();
    logic [CNT_W-1:0] d;
    wr(0, 1, 16'd3);
    arm_wr(0, 16'h7);
    pulse_done(0); pulse_done(0);
    rd(0, 1, d); chk("R7 count after two transfers", d, 1);
    chk("R8 no end irq yet", end_irq, 0);
    pulse_done(0);
    chk("R8 end irq on final count", end_irq, 2'b01);
    rd(0, 1, d); chk("R7 count reaches zero", d, 0);
    rd(0, 0, d); chk("R7 final count clears enable", d, 16'h6);
    chk("R8 end irq held", end_irq, 2'b01);
    wr(0, 0, 16'h2);
    chk("R8 end irq cancelled by enable bit 0", end_irq, 0);
    arm_wr(0, 16'h7); wr(0, 0, 16'h6);
    chk("R8 end irq on forced clear", end_irq, 2'b01);
    arm_wr(0, 16'h7);
    chk("R8 end irq cancelled by re-enable", end_irq, 0);
    wr(0, 0, 0);
    chk("R8 no end irq when its enable written 0", end_irq, 0);
  endtask

  task automatic t_break();
    wr(0, 0, 16'hA); wr(0, 0, 16'h8);
    chk("R9 break irq on master clear", brk_irq, 2'b01);
    @(negedge clk);
    chk("R9 break irq held", brk_irq, 2'b01);
    wr(0, 0, 16'hA);
    chk("R9 break irq cancelled by master set", brk_irq, 0);
    wr(0, 0, 16'h8);
    chk("R9 break irq raised again", brk_irq, 2'b01);
    wr(0, 0, 16'h0);
    chk("R9 break irq cancelled by enable bit 0", brk_irq, 0);
  endtask

  task automatic t_race();
    logic [CNT_W-1:0] d;
    wr(0, 1, 16'd1);
    arm_wr(0, 16'h3);
    act_req[0] = 1'b1; xfer_done[0] = 1'b1; #1;
    chk("R10 no start on final count", xfer_start, 0);
    @(negedge clk); act_req = '0; xfer_done = '0;
    rd(0, 0, d); chk("R10 enable cleared by final count", d, 16'h2);
    wr(0, 0, 16'h3);
    act_req[0] = 1'b1; reg_addr = 2'b00; reg_wdata = 16'h2; reg_wr = 1'b1; #1;
    chk("R10 no start on write of 0", xfer_start, 0);
    @(negedge clk); reg_wr = 1'b0; act_req = '0;
    wr(0, 0, 0);
  endtask

  task automatic t_indep();
    logic [CNT_W-1:0] d;
    rd(1, 0, d);
    wr(0, 0, 16'h1);
    rd(0, 0, d); chk("R11 read of other channel does not arm", d, 0);
    wr(0, 0, 16'h2);
    arm_wr(1, 16'h3);
    act_req = 2'b11; #1;
    chk("R11 only enabled channel starts", xfer_start, 2'b10);
    @(negedge clk); act_req = '0;
    wr(0, 0, 0); wr(1, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arming();
    t_start();
    t_pass();
    t_count();
    t_break();
    t_race();
    t_indep();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule